// File: doc/BRIEF.md
# Boost Frequency Target Calculator

This block is the arithmetic step a memory-activity monitor needs after it raises an interrupt. The inputs are the present boost value, the two consecutive-breach flags, the sampled average activity count, the current and maximum memory clock frequencies (in kHz), and a channel's coefficient set. From these it computes the next boost value and the new state of the two consecutive-breach interrupt enables. It also produces four watermarks for the monitor and the frequency target that the frequency governor should request.

A one-cycle `start` pulse latches every input, so the caller may change its inputs once the unit is busy. The unit then steps through a fixed sequence of shared multiply and divide operations. Each operation runs over several cycles, and every intermediate value is `FW+PW+4` bits wide so that no product overflows. At the end the unit pulses `done` for one cycle. All results are registered together on that cycle and keep their values until the next `done`. The boost step, the sampling period, the band in per-mille of the maximum frequency and the multiplier variant are parameters. Their defaults are a step of 16000, a period of 12, a band of 6 and an iterative multiplier.

Top module: `boost_calc`

## Requirements
- R1: After reset `busy`, `done`, `boost_out`, both enable outputs, all watermarks and `target` are 0.
- R2: When `brk_up` is 1, the new boost is `s = boost_in*up_pct/100 + STEP` (truncating division). If `s >= max_freq`, the new boost is `max_freq` and `en_above_out` keeps `en_above_in`. Otherwise the new boost is `s` and `en_above_out` is 1. On this path `en_below_out` is 1, subject to R5.
- R3: When only `brk_dn` is 1, the new boost is `q = boost_in*dn_pct/100`. If `q < STEP/2`, the new boost is 0 and `en_below_out` keeps `en_below_in`, subject to R5. Otherwise the new boost is `q` and `en_below_out` is 1. On this path `en_above_out` is 1.
- R4: `brk_up` takes precedence when both flags are 1. When neither flag is 1, the boost is unchanged and both enables pass through, subject to R5.
- R5: When `dep_thr != 0`, `en_below_out` is 1 whenever `avg_in >= dep_thr`. When `avg_in < dep_thr` and the new boost is 0, `en_below_out` is 0.
- R6: With `band = (max_freq*BAND_PERMILLE/1000)*PERIOD`, `avg_hi_wm = avg_in + band` and `avg_lo_wm = max(avg_in, band) - band`.
- R7: `hi_wm = cur_freq*PERIOD*up_thr/100` and `lo_wm = cur_freq*PERIOD*dn_thr/100`, each multiplied in full before the division.
- R8: `target = (avg_in/PERIOD) * (10000/up_thr) / 100 + new boost`. The caller keeps `up_thr` nonzero.
- R9: `done` is high for exactly one cycle per accepted start, and no output changes in any cycle without `done`.
- R10: A `start` that arrives while `busy` is 1 is ignored. The results come from the inputs latched at the accepted start, and no second `done` follows.
- R11: The time from an accepted start to `done` is the same fixed number of cycles for all operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation; inputs are latched when idle |
| brk_up | input | 1 | Consecutive-above breach flag |
| brk_dn | input | 1 | Consecutive-below breach flag |
| boost_in | input | FW | Present boost value (kHz) |
| avg_in | input | FW | Sampled average activity count |
| cur_freq | input | FW | Current memory clock (kHz) |
| max_freq | input | FW | Maximum memory clock (kHz) |
| up_pct | input | PW | Boost growth coefficient in percent |
| dn_pct | input | PW | Boost decay coefficient in percent |
| up_thr | input | PW | Upper threshold in percent (nonzero) |
| dn_thr | input | PW | Lower threshold in percent |
| dep_thr | input | FW | Activity dependency threshold, 0 disables |
| en_above_in | input | 1 | Present consecutive-above interrupt enable |
| en_below_in | input | 1 | Present consecutive-below interrupt enable |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| boost_out | output | FW | New boost value |
| en_above_out | output | 1 | New consecutive-above interrupt enable |
| en_below_out | output | 1 | New consecutive-below interrupt enable |
| avg_hi_wm | output | FW+PW+4 | Average upper watermark |
| avg_lo_wm | output | FW+PW+4 | Average lower watermark |
| hi_wm | output | FW+PW+4 | Upper watermark |
| lo_wm | output | FW+PW+4 | Lower watermark |
| target | output | FW+PW+4 | Frequency target (kHz) |

## Verification
All results fall due together on the single cycle in which `done` rises. That cycle comes a fixed number of cycles after the start edge. The bench counts falling edges from start to `done` on the first run and requires the same count on every later run. It reads each result at the falling edge on which `done` is first seen high. At the next falling edge it checks that `done` has dropped, that the results have held and that the unit has returned to idle. A start issued in the middle of a calculation, with altered inputs, must leave that calculation's results and its timing unchanged.

// File: rtl/boost_calc_pkg.sv
package boost_calc_pkg;

   // Sequence of shared arithmetic steps, one operation each.
   typedef enum logic [3:0] {
      ST_IDLE, ST_BMUL, ST_BDIV, ST_BANDM, ST_BANDD, ST_BANDP,
      ST_CPM, ST_UWM, ST_UWD, ST_LWM, ST_LWD,
      ST_TAD, ST_COEFD, ST_TM, ST_TD
   } step_t;

   function automatic logic step_is_div(step_t s);
      return (s == ST_BDIV) || (s == ST_BANDD) || (s == ST_UWD) ||
             (s == ST_LWD) || (s == ST_TAD) || (s == ST_COEFD) ||
             (s == ST_TD);
   endfunction

   function automatic step_t step_next(step_t s);
      if (s == ST_TD) return ST_IDLE;
      return step_t'(s + 4'd1);
   endfunction

endpackage

// File: rtl/boost_calc_mul.sv
module boost_calc_mul #(
   parameter int W    = 52,
   parameter bit FAST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         done,
   output logic [W-1:0] prod
);
   localparam int CW = $clog2(W + 1);

   generate
      if (FAST) begin : g_fast
         // single registered multiply, result one cycle after go
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prod <= '0;
               done <= 1'b0;
            end else begin
               done <= go;
               if (go) prod <= a * b;
            end
         end
      end else begin : g_iter
         // shift-add multiply, one multiplier bit per cycle
         logic [W-1:0]  acc, mc, mp;
         logic [CW-1:0] cnt;
         logic          run;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc  <= '0;
               mc   <= '0;
               mp   <= '0;
               cnt  <= '0;
               run  <= 1'b0;
               done <= 1'b0;
            end else begin
               done <= 1'b0;
               if (go) begin
                  acc <= '0;
                  mc  <= a;
                  mp  <= b;
                  cnt <= CW'(W);
                  run <= 1'b1;
               end else if (run) begin
                  if (mp[0]) acc <= acc + mc;
                  mc  <= mc << 1;
                  mp  <= mp >> 1;
                  cnt <= cnt - CW'(1);
                  if (cnt == CW'(1)) begin
                     run  <= 1'b0;
                     done <= 1'b1;
                  end
               end
            end
         end
         assign prod = acc;
      end
   endgenerate

endmodule

// File: rtl/boost_calc_div.sv
module boost_calc_div #(
   parameter int W = 52
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         done,
   output logic [W-1:0] quot
);
   localparam int CW = $clog2(W + 1);

   // restoring division, one quotient bit per cycle
   logic [W:0]    rem;
   logic [W-1:0]  quo, dvs;
   logic [CW-1:0] cnt;
   logic          run;
   logic [W:0]    shifted, diff;

   assign shifted = {rem[W-1:0], quo[W-1]};
   assign diff    = shifted - {1'b0, dvs};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem  <= '0;
         quo  <= '0;
         dvs  <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            rem <= '0;
            quo <= a;
            dvs <= b;
            cnt <= CW'(W);
            run <= 1'b1;
         end else if (run) begin
            if (!diff[W]) begin
               rem <= diff;
               quo <= {quo[W-2:0], 1'b1};
            end else begin
               rem <= shifted;
               quo <= {quo[W-2:0], 1'b0};
            end
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quot = quo;

endmodule

// File: rtl/boost_calc.sv
module boost_calc
   import boost_calc_pkg::*;
#(
   parameter int FW            = 32,
   parameter int PW            = 16,
   parameter int PERIOD        = 12,
   parameter int STEP          = 16000,
   parameter int BAND_PERMILLE = 6,
   parameter bit FAST_MUL      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              brk_up,
   input  logic              brk_dn,
   input  logic [FW-1:0]     boost_in,
   input  logic [FW-1:0]     avg_in,
   input  logic [FW-1:0]     cur_freq,
   input  logic [FW-1:0]     max_freq,
   input  logic [PW-1:0]     up_pct,
   input  logic [PW-1:0]     dn_pct,
   input  logic [PW-1:0]     up_thr,
   input  logic [PW-1:0]     dn_thr,
   input  logic [FW-1:0]     dep_thr,
   input  logic              en_above_in,
   input  logic              en_below_in,
   output logic              busy,
   output logic              done,
   output logic [FW-1:0]     boost_out,
   output logic              en_above_out,
   output logic              en_below_out,
   output logic [FW+PW+3:0]  avg_hi_wm,
   output logic [FW+PW+3:0]  avg_lo_wm,
   output logic [FW+PW+3:0]  hi_wm,
   output logic [FW+PW+3:0]  lo_wm,
   output logic [FW+PW+3:0]  target
);
   localparam int W        = FW + PW + 4;
   localparam int PCT_DIV  = 100;
   localparam int BAND_DIV = 1000;
   localparam int COEF_NUM = 10000;
   localparam int HALF     = STEP / 2;

   // elaboration-time parameter checks
   if (PERIOD < 1 || PERIOD > 15) begin : g_bad_period
      $error("PERIOD must lie in 1..15");
   end
   if (FW < 16 || PW < 8) begin : g_bad_width
      $error("FW must be at least 16 and PW at least 8");
   end
   if (STEP < 2 || STEP >= (1 << (FW - 1))) begin : g_bad_step
      $error("STEP out of range for FW");
   end

   // latched inputs
   logic          up_l, dn_l, ea_l, eb_l;
   logic [FW-1:0] boost_l, avg_l, cur_l, max_l, dep_l;
   logic [PW-1:0] upp_l, dnp_l, uth_l, dth_l;

   // sequence state and intermediates
   step_t        state;
   logic         issued;
   logic [W-1:0] acc_r, band_r, cp_r, hi_r, lo_r, ta_r, nb_r;
   logic         clamp_r, snap_r;

   // shared arithmetic units
   logic         is_div, issue, mul_go, div_go, mul_done, div_done, unit_done;
   logic [W-1:0] op_a, op_b, mul_res, div_res, res;

   assign busy   = (state != ST_IDLE);
   assign is_div = step_is_div(state);
   assign issue  = busy && !issued;
   assign mul_go = issue && !is_div;
   assign div_go = issue && is_div;
   assign res       = is_div ? div_res  : mul_res;
   assign unit_done = is_div ? div_done : mul_done;

   boost_calc_mul #(.W(W), .FAST(FAST_MUL)) u_mul (
      .clk(clk), .rst_n(rst_n), .go(mul_go), .a(op_a), .b(op_b),
      .done(mul_done), .prod(mul_res)
   );

   boost_calc_div #(.W(W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .a(op_a), .b(op_b),
      .done(div_done), .quot(div_res)
   );

   // operand selection per step
   always_comb begin
      op_a = '0;
      op_b = '0;
      case (state)
         ST_BMUL:  begin op_a = W'(boost_l);  op_b = W'(up_l ? upp_l : dnp_l); end
         ST_BDIV:  begin op_a = acc_r;        op_b = W'(PCT_DIV);              end
         ST_BANDM: begin op_a = W'(max_l);    op_b = W'(BAND_PERMILLE);        end
         ST_BANDD: begin op_a = acc_r;        op_b = W'(BAND_DIV);             end
         ST_BANDP: begin op_a = acc_r;        op_b = W'(PERIOD);               end
         ST_CPM:   begin op_a = W'(cur_l);    op_b = W'(PERIOD);               end
         ST_UWM:   begin op_a = cp_r;         op_b = W'(uth_l);                end
         ST_UWD:   begin op_a = acc_r;        op_b = W'(PCT_DIV);              end
         ST_LWM:   begin op_a = cp_r;         op_b = W'(dth_l);                end
         ST_LWD:   begin op_a = acc_r;        op_b = W'(PCT_DIV);              end
         ST_TAD:   begin op_a = W'(avg_l);    op_b = W'(PERIOD);               end
         ST_COEFD: begin op_a = W'(COEF_NUM); op_b = W'(uth_l);                end
         ST_TM:    begin op_a = ta_r;         op_b = acc_r;                    end
         ST_TD:    begin op_a = acc_r;        op_b = W'(PCT_DIV);              end
         default:  ;
      endcase
   end

   // boost update from the scaled boost quotient
   logic [W-1:0] sum_c, nb_c;
   logic         clamp_c, snap_c;
   always_comb begin
      sum_c   = res + W'(STEP);
      nb_c    = W'(boost_l);
      clamp_c = 1'b0;
      snap_c  = 1'b0;
      if (up_l) begin
         if (sum_c >= W'(max_l)) begin
            nb_c    = W'(max_l);
            clamp_c = 1'b1;
         end else begin
            nb_c = sum_c;
         end
      end else if (dn_l) begin
         if (res < W'(HALF)) begin
            nb_c   = '0;
            snap_c = 1'b1;
         end else begin
            nb_c = res;
         end
      end
   end

   // interrupt enable update
   logic ea_c, eb_c;
   always_comb begin
      ea_c = ea_l;
      eb_c = eb_l;
      if (up_l) begin
         eb_c = 1'b1;
         if (!clamp_r) ea_c = 1'b1;
      end else if (dn_l) begin
         ea_c = 1'b1;
         if (!snap_r) eb_c = 1'b1;
      end
      if (dep_l != '0) begin
         if (avg_l >= dep_l)    eb_c = 1'b1;
         else if (nb_r == '0)   eb_c = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         issued       <= 1'b0;
         up_l         <= 1'b0;
         dn_l         <= 1'b0;
         ea_l         <= 1'b0;
         eb_l         <= 1'b0;
         boost_l      <= '0;
         avg_l        <= '0;
         cur_l        <= '0;
         max_l        <= '0;
         dep_l        <= '0;
         upp_l        <= '0;
         dnp_l        <= '0;
         uth_l        <= '0;
         dth_l        <= '0;
         acc_r        <= '0;
         band_r       <= '0;
         cp_r         <= '0;
         hi_r         <= '0;
         lo_r         <= '0;
         ta_r         <= '0;
         nb_r         <= '0;
         clamp_r      <= 1'b0;
         snap_r       <= 1'b0;
         done         <= 1'b0;
         boost_out    <= '0;
         en_above_out <= 1'b0;
         en_below_out <= 1'b0;
         avg_hi_wm    <= '0;
         avg_lo_wm    <= '0;
         hi_wm        <= '0;
         lo_wm        <= '0;
         target       <= '0;
      end else begin
         done <= 1'b0;
         if (state == ST_IDLE) begin
            if (start) begin
               up_l    <= brk_up;
               dn_l    <= brk_dn;
               ea_l    <= en_above_in;
               eb_l    <= en_below_in;
               boost_l <= boost_in;
               avg_l   <= avg_in;
               cur_l   <= cur_freq;
               max_l   <= max_freq;
               dep_l   <= dep_thr;
               upp_l   <= up_pct;
               dnp_l   <= dn_pct;
               uth_l   <= up_thr;
               dth_l   <= dn_thr;
               issued  <= 1'b0;
               state   <= ST_BMUL;
            end
         end else if (!issued) begin
            issued <= 1'b1;
         end else if (unit_done) begin
            issued <= 1'b0;
            acc_r  <= res;
            state  <= step_next(state);
            case (state)
               ST_BDIV: begin
                  nb_r    <= nb_c;
                  clamp_r <= clamp_c;
                  snap_r  <= snap_c;
               end
               ST_BANDP: band_r <= res;
               ST_CPM:   cp_r   <= res;
               ST_UWD:   hi_r   <= res;
               ST_LWD:   lo_r   <= res;
               ST_TAD:   ta_r   <= res;
               ST_TD: begin
                  done         <= 1'b1;
                  boost_out    <= nb_r[FW-1:0];
                  en_above_out <= ea_c;
                  en_below_out <= eb_c;
                  avg_hi_wm    <= W'(avg_l) + band_r;
                  avg_lo_wm    <= (W'(avg_l) >= band_r) ? (W'(avg_l) - band_r) : '0;
                  hi_wm        <= hi_r;
                  lo_wm        <= lo_r;
                  target       <= res + nb_r;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/boost_calc_chk.sv
module boost_calc_chk #(
   parameter int FW   = 32,
   parameter int W    = 52,
   parameter int STEP = 16000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [FW-1:0] boost_out,
   input logic [W-1:0]  target,
   input logic [W-1:0]  avg_hi_wm,
   input logic [W-1:0]  avg_lo_wm,
   input logic [FW-1:0] max_l,
   input logic          up_l,
   input logic          dn_l
);
   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: results move only together with done
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(boost_out) && $stable(target)));

   // R10: an idle start always begins a calculation
   a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R2: a grown boost never exceeds the maximum frequency
   a_r2_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (done && up_l) |-> (boost_out <= max_l));

   // R3: a decayed boost is either zero or at least half a step
   a_r3_snap: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !up_l && dn_l) |-> ((boost_out == '0) || (boost_out >= FW'(STEP / 2))));

   // R6: the lower average watermark never passes the upper one
   a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (avg_lo_wm <= avg_hi_wm));
endmodule

bind boost_calc boost_calc_chk #(.FW(FW), .W(W), .STEP(STEP)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .boost_out(boost_out), .target(target),
   .avg_hi_wm(avg_hi_wm), .avg_lo_wm(avg_lo_wm),
   .max_l(max_l), .up_l(up_l), .dn_l(dn_l)
);

// File: tb/boost_calc_test.sv
`timescale 1ns/1ps
module boost_calc_test;
   localparam int FW = 32, PW = 16, W = FW + PW + 4;
   localparam longint PERIOD = 12, STEP = 16000, BANDPM = 6;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic brk_up = 0, brk_dn = 0, en_above_in = 0, en_below_in = 0;
   logic [FW-1:0] boost_in = '0, avg_in = '0, cur_freq = '0, max_freq = '0, dep_thr = '0;
   logic [PW-1:0] up_pct = '0, dn_pct = '0, up_thr = 16'd1, dn_thr = '0;
   logic busy, done, en_above_out, en_below_out;
   logic [FW-1:0] boost_out;
   logic [W-1:0]  avg_hi_wm, avg_lo_wm, hi_wm, lo_wm, target;

   always #2 clk = ~clk;   // 250 MHz

   boost_calc uut (
      .clk(clk), .rst_n(rst_n), .start(start), .brk_up(brk_up), .brk_dn(brk_dn),
      .boost_in(boost_in), .avg_in(avg_in), .cur_freq(cur_freq), .max_freq(max_freq),
      .up_pct(up_pct), .dn_pct(dn_pct), .up_thr(up_thr), .dn_thr(dn_thr),
      .dep_thr(dep_thr), .en_above_in(en_above_in), .en_below_in(en_below_in),
      .busy(busy), .done(done), .boost_out(boost_out),
      .en_above_out(en_above_out), .en_below_out(en_below_out),
      .avg_hi_wm(avg_hi_wm), .avg_lo_wm(avg_lo_wm), .hi_wm(hi_wm), .lo_wm(lo_wm),
      .target(target)
   );

   int n_checks = 0, n_errors = 0, ref_lat = -1;
   logic [63:0] e_boost, e_ahi, e_alo, e_hi, e_lo, e_tgt;
   logic e_ea, e_eb;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected results computed from the requirements
   task automatic model();
      logic [63:0] b, m, q, s, band, cp, nb;
      b = 64'(boost_in); m = 64'(max_freq);
      e_ea = en_above_in; e_eb = en_below_in;
      if (brk_up) begin
         s = b * up_pct / 100 + STEP;
         e_eb = 1'b1;
         if (s >= m) nb = m; else begin nb = s; e_ea = 1'b1; end
      end else if (brk_dn) begin
         q = b * dn_pct / 100;
         e_ea = 1'b1;
         if (q < STEP / 2) nb = 0; else begin nb = q; e_eb = 1'b1; end
      end else nb = b;
      if (dep_thr != 0) begin
         if (avg_in >= dep_thr) e_eb = 1'b1;
         else if (nb == 0) e_eb = 1'b0;
      end
      e_boost = nb;
      band  = ((m * BANDPM) / 1000) * PERIOD;
      e_ahi = 64'(avg_in) + band;
      e_alo = (64'(avg_in) >= band) ? 64'(avg_in) - band : 0;
      cp    = 64'(cur_freq) * PERIOD;
      e_hi  = cp * up_thr / 100;
      e_lo  = cp * dn_thr / 100;
      e_tgt = (64'(avg_in) / PERIOD) * (10000 / 64'(up_thr)) / 100 + nb;
   endtask

   // one calculation; poke issues an extra start with altered inputs mid-run
   task automatic run(bit poke);
      string pt, et;
      int lat;
      logic [FW-1:0] held;
      pt = (brk_up && brk_dn) ? "R4" : brk_up ? "R2" : brk_dn ? "R3" : "R4";
      et = (dep_thr != 0) ? "R5" : pt;
      model();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0; lat = 1;
      while (!done && lat < 5000) begin
         if (poke && lat == 5) begin
            start = 1'b1; boost_in = boost_in ^ 32'h5a5a; avg_in = avg_in + 1234;
            brk_up = ~brk_up; max_freq = max_freq + 777;
         end else start = 1'b0;
         @(negedge clk); lat++;
      end
      start = 1'b0;
      if (ref_lat < 0) ref_lat = lat;
      chk("R11 latency", 64'(lat), 64'(ref_lat));
      chk(pt, 64'(boost_out), e_boost);
      chk({et, " above"}, 64'(en_above_out), 64'(e_ea));
      chk({et, " below"}, 64'(en_below_out), 64'(e_eb));
      chk("R6 hi", 64'(avg_hi_wm), e_ahi);
      chk("R6 lo", 64'(avg_lo_wm), e_alo);
      chk("R7 hi", 64'(hi_wm), e_hi);
      chk("R7 lo", 64'(lo_wm), e_lo);
      chk("R8", 64'(target), e_tgt);
      held = boost_out;
      @(negedge clk);
      chk("R9 pulse", 64'(done), 0);
      chk("R9 hold", 64'(boost_out), 64'(held));
      if (poke) chk("R10 idle", 64'(busy), 0);
   endtask

   task automatic setv(bit u, bit d, longint b, longint a, longint c, longint mx,
                       int up, int dn, int ut, int dt, longint dep, bit ea, bit eb);
      brk_up = u; brk_dn = d; boost_in = FW'(b); avg_in = FW'(a); cur_freq = FW'(c);
      max_freq = FW'(mx); up_pct = PW'(up); dn_pct = PW'(dn); up_thr = PW'(ut);
      dn_thr = PW'(dt); dep_thr = FW'(dep); en_above_in = ea; en_below_in = eb;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog R11 actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 64'(busy), 0);
      chk("R1 done", 64'(done), 0);
      chk("R1 boost", 64'(boost_out), 0);
      chk("R1 enables", 64'({en_above_out, en_below_out}), 0);
      chk("R1 target", 64'(target), 0);
      chk("R1 wm", 64'(avg_hi_wm | avg_lo_wm | hi_wm | lo_wm), 0);
      // R2 clamp keeps the above enable, R2 no clamp sets it
      setv(1, 0, 900000, 500000, 800000, 1000000, 200, 50, 60, 40, 0, 0, 0); run(0);
      setv(1, 0, 0, 500000, 800000, 1000000, 200, 50, 60, 40, 0, 0, 0); run(0);
      // R3 snap to zero below 8000, edge exactly at 8000
      setv(0, 1, 15000, 300000, 600000, 1000000, 200, 50, 60, 40, 0, 0, 0); run(0);
      setv(0, 1, 16000, 300000, 600000, 1000000, 200, 50, 60, 40, 0, 0, 0); run(0);
      // R4 both flags, then neither flag
      setv(1, 1, 40000, 200000, 500000, 1000000, 200, 50, 60, 40, 0, 0, 0); run(0);
      setv(0, 0, 40000, 200000, 500000, 1000000, 200, 50, 60, 40, 0, 1, 0); run(0);
      // R5 dependency forces the below enable on and off
      setv(0, 0, 0, 60000, 500000, 1000000, 800, 90, 27, 10, 50000, 0, 0); run(0);
      setv(0, 0, 0, 40000, 500000, 1000000, 800, 90, 27, 10, 50000, 0, 1); run(0);
      // R6 average below the band
      setv(0, 0, 0, 100, 204000, 1000000, 200, 50, 60, 40, 0, 0, 0); run(0);
      // R10 start during a calculation is ignored
      setv(1, 0, 20000, 700000, 900000, 2000000, 200, 50, 60, 40, 0, 0, 1); run(1);
      // randomized operands
      for (int i = 0; i < 50; i++) begin
         longint mx, c;
         int ut;
         mx = $urandom_range(2000000, 100000);
         c  = $urandom_range(32'(mx), 1000);
         ut = $urandom_range(100, 1);
         setv($urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(32'(mx) + 50000, 0),
              $urandom_range(30000000, 0), c, mx, $urandom_range(900, 100),
              $urandom_range(99, 5), ut, $urandom_range(ut, 0),
              ($urandom_range(1, 0) != 0) ? longint'($urandom_range(5000000, 1)) : 0,
              $urandom_range(1, 0), $urandom_range(1, 0));
         run(i % 10 == 3);
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule